// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block moves data between two rings of descriptors that live in ordinary memory. Software fills source descriptors and then raises the source write index. The engine walks the source ring from its own read index. For each transfer it claims the next posted destination descriptor and copies the referenced source words into that destination buffer. When the transfer ends, it writes the transfer's byte count and flags back into the destination descriptor. It then raises a one-cycle copy-complete pulse and advances the destination read index.

A transfer may be split across several source descriptors. Fragments marked as gather are concatenated into a single destination buffer. Data words can be byte-reversed when they are read, when they are written, or both. Two kinds of bad descriptor are reported on dedicated pulse outputs: an empty descriptor, and a fragment that would push the transfer past the configured maximum length. A halt command parks the engine at the next descriptor boundary and reports when the engine is parked.

All memory traffic goes over one word-addressed port. A read returns its data on the cycle after the request. Configuration uses a small word-addressed register bus with a combinational read path.

Top module: `ce_copy_engine`

## Requirements
- R1: After reset, both read indices, both write indices, the halt request and the halt-done status read as zero. No event pulse is raised.
- R2: Descriptor i of a ring occupies two memory words at ring base + 2*i. The first word is the buffer word address. The second word has the byte count in bits 15:0 and the flags in bits 31:16. Within the flags, bit 0 means gather (more fragments follow), bit 1 requests a swap, and bits 15:2 carry a 14-bit metadata value.
- R3: A non-gather descriptor with a nonzero byte count n copies ceil(n/4) words from its source buffer to the buffer of the next posted destination descriptor. It leaves later destination words untouched. Both read indices then advance by one.
- R4: Consecutive gather fragments and the non-gather fragment that ends them fill one destination buffer contiguously. They consume one destination entry and produce one copy-complete pulse.
- R5: At the end of a transfer, word 1 of the destination descriptor receives the total byte count in bits 15:0 and the flags in bits 31:16. Those flags hold the last fragment's metadata in bits 15:2, the net swap state in bit 1, and 0 in bit 0. copy_done pulses in the cycle after that write.
- R6: A word is byte-reversed on read when the descriptor's swap flag or ctrl bit 16 is set. It is reversed again on write when ctrl bit 17 is set, so both stages together cancel. The net swap bit written back is the exclusive-or of the two stages.
- R7: A source descriptor with a zero byte count pulses err_src_len, moves no data and advances the source read index. It does not consume a destination entry on its own.
- R8: A fragment that would bring the running total above ctrl bits 15:0 pulses err_dst_max and is dropped. The transfer still completes with the total of the fragments already copied.
- R9: When a transfer needs a destination entry and the destination read index equals its write index, the engine waits without touching memory. It resumes once an entry is posted.
- R10: Writing 1 to cmd bit 0 stops the engine from starting a new descriptor. Cmd bit 3 reads 1 while the halt request is set and the engine is parked. Writing 0 resumes processing.
- R11: Source entries are processed only while the source read index differs from the source write index. All indices wrap modulo the power-of-two ring size.
- R12: The register word addresses are: 0 source ring base, 1 destination ring base, 2 ctrl (bits 15:0 maximum length, bit 16 read swap, bit 17 write swap), 3 cmd, 4 source write index, 5 destination write index, 6 source read index (read only), and 7 destination read index (read only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable (0 = read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| copy_done | output | 1 | One-cycle pulse after a transfer is written back |
| err_src_len | output | 1 | One-cycle pulse for a zero-length source descriptor |
| err_dst_max | output | 1 | One-cycle pulse for a fragment beyond the maximum length |

## Verification
Two interactions are provoked on purpose. In the first, software posts new source descriptors while the engine is parked waiting for a destination entry. The bench checks that the source read index stays put and that no completion pulse appears until a destination is posted, after which the copy lands intact. In the second, the halt request is raised before descriptors are posted. The bench checks that the halt-done bit reads back, that nothing is consumed, and that clearing the request releases exactly the pending transfer. A final readback of both read indices, taken after the rings have wrapped, confirms that no entry was skipped or consumed twice.

// File: rtl/ce_pkg.sv
package ce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SD0,
        ST_SD0W,
        ST_SD1,
        ST_SD1W,
        ST_DD,
        ST_DDW,
        ST_RD,
        ST_RDW,
        ST_WB,
        ST_FIN
    } ce_state_e;

    localparam int FLG_GATHER   = 0;
    localparam int FLG_SWAP     = 1;
    localparam int CTL_SRC_SWAP = 16;
    localparam int CTL_DST_SWAP = 17;
    localparam int CMD_HALT     = 0;
    localparam int CMD_PARKED   = 3;

    localparam logic [2:0] RA_SRC_BASE = 3'd0;
    localparam logic [2:0] RA_DST_BASE = 3'd1;
    localparam logic [2:0] RA_CTRL     = 3'd2;
    localparam logic [2:0] RA_CMD      = 3'd3;
    localparam logic [2:0] RA_SRC_WR   = 3'd4;
    localparam logic [2:0] RA_DST_WR   = 3'd5;
    localparam logic [2:0] RA_SRC_RD   = 3'd6;
    localparam logic [2:0] RA_DST_RD   = 3'd7;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] nbytes;
    } desc_ctl_t;

    typedef struct packed {
        logic [15:0] max_len;
        logic        src_swap;
        logic        dst_swap;
        logic        halt;
    } ce_cfg_t;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [15:0] words_of(input logic [15:0] nbytes);
        return {2'b00, nbytes[15:2]} + {15'd0, |nbytes[1:0]};
    endfunction

endpackage

// File: rtl/ce_ring_ptr.sv
module ce_ring_ptr #(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic          empty
);
    always_ff @(posedge clk) begin
        if (rst)
            rd_idx <= '0;
        else if (adv)
            rd_idx <= rd_idx + 1'b1;
    end

    assign empty = (rd_idx == wr_idx);

    // R11
    adv_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        adv |-> !empty);

endmodule

// File: rtl/ce_regs.sv
module ce_regs
    import ce_pkg::*;
#(
    parameter int AW  = 10,
    parameter int SIW = 3,
    parameter int DIW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [SIW-1:0] src_rd,
    input  logic [DIW-1:0] dst_rd,
    input  logic           engine_idle,
    output logic [AW-1:0]  src_base,
    output logic [AW-1:0]  dst_base,
    output ce_cfg_t        cfg,
    output logic [SIW-1:0] src_wr,
    output logic [DIW-1:0] dst_wr
);
    logic parked;
    logic unused_bits;

    assign unused_bits = ^reg_wdata[31:18];
    assign parked = cfg.halt && engine_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            cfg      <= '0;
            src_wr   <= '0;
            dst_wr   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_SRC_BASE: src_base <= reg_wdata[AW-1:0];
                RA_DST_BASE: dst_base <= reg_wdata[AW-1:0];
                RA_CTRL: begin
                    cfg.max_len  <= reg_wdata[15:0];
                    cfg.src_swap <= reg_wdata[CTL_SRC_SWAP];
                    cfg.dst_swap <= reg_wdata[CTL_DST_SWAP];
                end
                RA_CMD:    cfg.halt <= reg_wdata[CMD_HALT];
                RA_SRC_WR: src_wr   <= reg_wdata[SIW-1:0];
                RA_DST_WR: dst_wr   <= reg_wdata[DIW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SRC_BASE: reg_rdata = 32'(src_base);
            RA_DST_BASE: reg_rdata = 32'(dst_base);
            RA_CTRL:     reg_rdata = {14'd0, cfg.dst_swap, cfg.src_swap, cfg.max_len};
            RA_CMD:      reg_rdata = {28'd0, parked, 2'b00, cfg.halt};
            RA_SRC_WR:   reg_rdata = 32'(src_wr);
            RA_DST_WR:   reg_rdata = 32'(dst_wr);
            RA_SRC_RD:   reg_rdata = 32'(src_rd);
            RA_DST_RD:   reg_rdata = 32'(dst_rd);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ce_engine.sv
module ce_engine
    import ce_pkg::*;
#(
    parameter int AW  = 10,
    parameter int SIW = 3,
    parameter int DIW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  src_base,
    input  logic [AW-1:0]  dst_base,
    input  ce_cfg_t        cfg,
    input  logic           src_empty,
    input  logic           dst_empty,
    input  logic [SIW-1:0] src_idx,
    input  logic [DIW-1:0] dst_idx,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    output logic           src_adv,
    output logic           dst_adv,
    output logic           idle,
    output logic           copy_done,
    output logic           err_src_len,
    output logic           err_dst_max
);
    ce_state_e   st;
    logic [AW-1:0] src_ptr, dst_ptr;
    logic [15:0] frag_flags;
    logic [15:0] words_left;
    logic [16:0] total;
    logic        dst_open;
    logic        rd_swap;
    logic        net_swap;

    desc_ctl_t   dctl;
    logic [17:0] sum;
    logic        len_zero, over, do_copy, last_word;
    logic [AW-1:0] src_slot, dst_slot;
    logic [31:0] rd_word, wr_word;

    assign dctl     = desc_ctl_t'(mem_rdata);
    assign sum      = {1'b0, total} + {2'b00, dctl.nbytes};
    assign len_zero = (dctl.nbytes == 16'd0);
    assign over     = (sum > {2'b00, cfg.max_len});
    assign do_copy  = !len_zero && !over;
    assign last_word = (words_left == 16'd1);

    assign src_slot = src_base + AW'({src_idx, 1'b0});
    assign dst_slot = dst_base + AW'({dst_idx, 1'b0});

    assign rd_word = rd_swap ? swap_bytes(mem_rdata) : mem_rdata;
    assign wr_word = cfg.dst_swap ? swap_bytes(rd_word) : rd_word;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_SD0: begin
                mem_req  = 1'b1;
                mem_addr = src_slot;
            end
            ST_SD1: begin
                mem_req  = 1'b1;
                mem_addr = src_slot + 1'b1;
            end
            ST_DD: begin
                mem_req  = !dst_empty;
                mem_addr = dst_slot;
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_ptr;
            end
            ST_RDW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_ptr;
                mem_wdata = wr_word;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_slot + 1'b1;
                mem_wdata = {frag_flags[15:2], net_swap, 1'b0, total[15:0]};
            end
            default: ;
        endcase
    end

    assign src_adv     = ((st == ST_SD1W) && !do_copy) || ((st == ST_RDW) && last_word);
    assign dst_adv     = (st == ST_FIN);
    assign copy_done   = (st == ST_FIN);
    assign err_src_len = (st == ST_SD1W) && len_zero;
    assign err_dst_max = (st == ST_SD1W) && !len_zero && over;
    assign idle        = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            src_ptr    <= '0;
            dst_ptr    <= '0;
            frag_flags <= '0;
            words_left <= '0;
            total      <= '0;
            dst_open   <= 1'b0;
            rd_swap    <= 1'b0;
            net_swap   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (!cfg.halt && !src_empty) st <= ST_SD0;
                ST_SD0:  st <= ST_SD0W;
                ST_SD0W: begin
                    src_ptr <= mem_rdata[AW-1:0];
                    st      <= ST_SD1;
                end
                ST_SD1:  st <= ST_SD1W;
                ST_SD1W: begin
                    frag_flags <= dctl.flags;
                    words_left <= words_of(dctl.nbytes);
                    if (do_copy) begin
                        total    <= sum[16:0];
                        rd_swap  <= dctl.flags[FLG_SWAP] | cfg.src_swap;
                        net_swap <= (dctl.flags[FLG_SWAP] | cfg.src_swap) ^ cfg.dst_swap;
                        st       <= dst_open ? ST_RD : ST_DD;
                    end else begin
                        st <= (dst_open && !dctl.flags[FLG_GATHER]) ? ST_WB : ST_IDLE;
                    end
                end
                ST_DD:   if (!dst_empty) st <= ST_DDW;
                ST_DDW: begin
                    dst_ptr  <= mem_rdata[AW-1:0];
                    dst_open <= 1'b1;
                    st       <= ST_RD;
                end
                ST_RD:   st <= ST_RDW;
                ST_RDW: begin
                    src_ptr    <= src_ptr + 1'b1;
                    dst_ptr    <= dst_ptr + 1'b1;
                    words_left <= words_left - 1'b1;
                    if (last_word)
                        st <= frag_flags[FLG_GATHER] ? ST_IDLE : ST_WB;
                    else
                        st <= ST_RD;
                end
                ST_WB:   st <= ST_FIN;
                ST_FIN: begin
                    total    <= '0;
                    dst_open <= 1'b0;
                    net_swap <= 1'b0;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5
    wb_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        copy_done |-> $past(mem_req && mem_we));

    // R9
    dst_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DD && dst_empty) |=> (st == ST_DD));

    // R7
    evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({copy_done, err_src_len, err_dst_max}));

    // R3
    dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dst_adv |-> !src_adv);

endmodule

// File: rtl/ce_copy_engine.sv
module ce_copy_engine
    import ce_pkg::*;
#(
    parameter int AW          = 10,
    parameter int SRC_ENTRIES = 8,
    parameter int DST_ENTRIES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          copy_done,
    output logic          err_src_len,
    output logic          err_dst_max
);
    localparam int SIW = $clog2(SRC_ENTRIES);
    localparam int DIW = $clog2(DST_ENTRIES);

    logic [AW-1:0]  src_base, dst_base;
    ce_cfg_t        cfg;
    logic [SIW-1:0] src_wr, src_rd;
    logic [DIW-1:0] dst_wr, dst_rd;
    logic           src_empty, dst_empty, src_adv, dst_adv, idle;

    ce_regs #(.AW(AW), .SIW(SIW), .DIW(DIW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_rd(src_rd), .dst_rd(dst_rd), .engine_idle(idle),
        .src_base(src_base), .dst_base(dst_base), .cfg(cfg),
        .src_wr(src_wr), .dst_wr(dst_wr)
    );

    ce_ring_ptr #(.ENTRIES(SRC_ENTRIES)) u_src_ptr (
        .clk(clk), .rst(rst), .adv(src_adv), .wr_idx(src_wr),
        .rd_idx(src_rd), .empty(src_empty)
    );

    ce_ring_ptr #(.ENTRIES(DST_ENTRIES)) u_dst_ptr (
        .clk(clk), .rst(rst), .adv(dst_adv), .wr_idx(dst_wr),
        .rd_idx(dst_rd), .empty(dst_empty)
    );

    ce_engine #(.AW(AW), .SIW(SIW), .DIW(DIW)) u_engine (
        .clk(clk), .rst(rst),
        .src_base(src_base), .dst_base(dst_base), .cfg(cfg),
        .src_empty(src_empty), .dst_empty(dst_empty),
        .src_idx(src_rd), .dst_idx(dst_rd),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_adv(src_adv), .dst_adv(dst_adv), .idle(idle),
        .copy_done(copy_done), .err_src_len(err_src_len), .err_dst_max(err_dst_max)
    );

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.halt && idle) |=> !mem_req);

endmodule

// File: tb/sim_ce_copy_engine.sv
module sim_ce_copy_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam logic [AW-1:0] SRC_RING = 10'h000;
    localparam logic [AW-1:0] DST_RING = 10'h020;
    localparam logic [31:0]   PATTERN  = 32'h0A0B0C00;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] flags;
        logic [1:0]  csw;
        logic [31:0] wb;
        logic [31:0] w0;
        logic [3:0]  nw;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{16'd8,  16'h0014, 2'b00, 32'h00140008, 32'h0A0B0C00, 4'd2},
        '{16'd5,  16'h0002, 2'b00, 32'h00020005, 32'h000C0B0A, 4'd2},
        '{16'd4,  16'h0000, 2'b01, 32'h00020004, 32'h000C0B0A, 4'd1},
        '{16'd12, 16'h0002, 2'b10, 32'h0000000C, 32'h0A0B0C00, 4'd3},
        '{16'd4,  16'h0000, 2'b10, 32'h00020004, 32'h000C0B0A, 4'd1},
        '{16'd3,  16'hFFFC, 2'b00, 32'hFFFC0003, 32'h0A0B0C00, 4'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic copy_done, err_src_len, err_dst_max;

    logic [31:0] mem [0:1023];
    int n_checks = 0, n_fail = 0;
    int done_cnt = 0, esl_cnt = 0, edm_cnt = 0;
    logic [2:0] swr = '0, dwr = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ce_copy_engine #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .copy_done(copy_done), .err_src_len(err_src_len), .err_dst_max(err_dst_max)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
        if (!rst) begin
            if (copy_done)   done_cnt <= done_cnt + 1;
            if (err_src_len) esl_cnt  <= esl_cnt + 1;
            if (err_dst_max) edm_cnt  <= edm_cnt + 1;
        end
    end

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic post_src(input logic [AW-1:0] a, input logic [15:0] len, input logic [15:0] fl);
        mem[SRC_RING + 10'(2*swr)]     = 32'(a);
        mem[SRC_RING + 10'(2*swr) + 1] = {fl, len};
        swr = swr + 1'b1;
        wr_reg(3'd4, 32'(swr));
    endtask

    task automatic post_dst(input logic [AW-1:0] a, output logic [AW-1:0] wb_addr);
        mem[DST_RING + 10'(2*dwr)] = 32'(a);
        wb_addr = DST_RING + 10'(2*dwr) + 1;
        dwr = dwr + 1'b1;
        wr_reg(3'd5, 32'(dwr));
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_cnt < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [AW-1:0] wba;
        int base_done;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
        for (int k = 0; k < 16; k++) mem[10'h100 + k] = PATTERN + k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(3'd6, r); check(r == 0, "R1 src rd idx", r, 0);
        rd_reg(3'd7, r); check(r == 0, "R1 dst rd idx", r, 0);
        rd_reg(3'd3, r); check(r == 0, "R1 cmd/halt status", r, 0);
        check(done_cnt + esl_cnt + edm_cnt == 0, "R1 no events", 32'(done_cnt + esl_cnt + edm_cnt), 0);

        wr_reg(3'd0, 32'(SRC_RING));
        wr_reg(3'd1, 32'(DST_RING));
        // R12 ctrl readback
        wr_reg(3'd2, 32'h0003_0040);
        rd_reg(3'd2, r); check(r == 32'h0003_0040, "R12 ctrl readback", r, 32'h0003_0040);

        // R2 R3 R5 R6: table of single-descriptor transfers
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] dbuf;
            logic [31:0] last_exp, raw_last;
            dbuf = 10'h200 + 10'(16*i);
            wr_reg(3'd2, {14'd0, TBL[i].csw, 16'd64});
            base_done = done_cnt;
            post_dst(dbuf, wba);
            post_src(10'h100, TBL[i].len, TBL[i].flags);
            wait_done(base_done + 1);
            raw_last = PATTERN + 32'(TBL[i].nw) - 1;
            last_exp = TBL[i].wb[17] ? bswap(raw_last) : raw_last;
            check(mem[wba] == TBL[i].wb, "R5 writeback word", mem[wba], TBL[i].wb);
            check(mem[dbuf] == TBL[i].w0, "R6 first data word", mem[dbuf], TBL[i].w0);
            check(mem[dbuf + 10'(TBL[i].nw) - 1] == last_exp, "R3 last data word",
                  mem[dbuf + 10'(TBL[i].nw) - 1], last_exp);
            check(mem[dbuf + 10'(TBL[i].nw)] == 32'hDEADBEEF, "R3 guard word untouched",
                  mem[dbuf + 10'(TBL[i].nw)], 32'hDEADBEEF);
        end

        // R4 gather: 8 + 4 bytes into one buffer
        wr_reg(3'd2, 32'd64);
        base_done = done_cnt;
        post_dst(10'h300, wba);
        post_src(10'h100, 16'd8, 16'h0001);
        post_src(10'h108, 16'd4, 16'h0028);
        wait_done(base_done + 1);
        check(mem[wba] == 32'h0028000C, "R4 gather writeback", mem[wba], 32'h0028000C);
        check(mem[10'h302] == PATTERN + 8, "R4 gather third word", mem[10'h302], PATTERN + 8);
        check(done_cnt == base_done + 1, "R4 single completion", 32'(done_cnt), 32'(base_done + 1));

        // R7 zero-length descriptor
        base_done = done_cnt;
        post_src(10'h100, 16'd0, 16'h0000);
        idle_cycles(30);
        check(esl_cnt == 1, "R7 zero length error", 32'(esl_cnt), 1);
        rd_reg(3'd6, r); check(r == 32'(swr), "R7 src idx advanced", r, 32'(swr));
        rd_reg(3'd7, r); check(r == 32'(dwr), "R7 dst entry untouched", r, 32'(dwr));

        // R8 maximum length violation
        wr_reg(3'd2, 32'd8);
        base_done = done_cnt;
        post_dst(10'h320, wba);
        post_src(10'h100, 16'd4, 16'h0001);
        post_src(10'h104, 16'd12, 16'h0000);
        wait_done(base_done + 1);
        check(edm_cnt == 1, "R8 max length error", 32'(edm_cnt), 1);
        check(mem[wba] == 32'h00000004, "R8 partial total", mem[wba], 32'h00000004);
        check(mem[10'h321] == 32'hDEADBEEF, "R8 dropped fragment", mem[10'h321], 32'hDEADBEEF);

        // R9 destination stall while new source work is posted
        wr_reg(3'd2, 32'd64);
        base_done = done_cnt;
        post_src(10'h100, 16'd4, 16'h0000);
        idle_cycles(40);
        rd_reg(3'd6, r); check(r == 32'(swr - 1'b1), "R9 src held while stalled", r, 32'(swr - 1'b1));
        check(done_cnt == base_done, "R9 no completion while stalled", 32'(done_cnt), 32'(base_done));
        post_dst(10'h330, wba);
        wait_done(base_done + 1);
        check(mem[10'h330] == PATTERN, "R9 data after resume", mem[10'h330], PATTERN);

        // R10 halt
        wr_reg(3'd3, 32'd1);
        idle_cycles(3);
        rd_reg(3'd3, r); check(r == 32'h9, "R10 halt status", r, 32'h9);
        base_done = done_cnt;
        post_dst(10'h340, wba);
        post_src(10'h101, 16'd4, 16'h0000);
        idle_cycles(40);
        rd_reg(3'd6, r); check(r == 32'(swr - 1'b1), "R10 nothing consumed", r, 32'(swr - 1'b1));
        wr_reg(3'd3, 32'd0);
        wait_done(base_done + 1);
        check(mem[10'h340] == PATTERN + 1, "R10 resumed copy", mem[10'h340], PATTERN + 1);

        // R11 wrap: more than eight entries consumed on each ring
        rd_reg(3'd6, r); check(r == 32'(swr), "R11 src idx after wrap", r, 32'(swr));
        rd_reg(3'd7, r); check(r == 32'(dwr), "R11 dst idx after wrap", r, 32'(dwr));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule